// File: doc/BRIEF.md
# Halt-Triggered Periodic Restart Timer

This block restarts a small coprocessor program at a fixed interval. Once the program reports that it has halted, a counter runs. When the counter reaches the length held in the currently selected interval register, the block emits a one-cycle restart pulse. The pulse comes with the entry address that the host last used to launch the program. The coprocessor sequencer is expected to branch to that address on the pulse. The program never resumes from the point where it halted.

There are five interval registers, which the host loads. The running program picks which of them governs later intervals by driving an index with a strobe. A level enable lets the program or the host stop all future restarts. Dropping the enable does not interrupt a program that is already running, because the block only ever acts while the program is halted. The interval length is captured at the moment counting begins. A change of selection or of register contents during a count therefore applies from the next halt. An interval of zero is stretched to one cycle, so a restart can never coincide with the cycle in which the halt is first seen.

Top module: `halt_restart_timer`

## Requirements
- R1: After reset, restart_pulse is 0, active_sel is 0, restart_addr is 0, and every interval register holds RST_PERIOD (default 8).
- R2: With timer_en=1, let E be the clock edge at which prog_halted=1 is first sampled while the block is idle. restart_pulse rises after the edge L cycles later, where L is the effective length of the selected register. The pulse stays high for exactly one cycle.
- R3: A cycle with cfg_we=1 loads cfg_data into the register numbered cfg_idx (0..4). A write with cfg_idx of 5 or more changes no register.
- R4: A cycle with sel_stb=1 and sel_idx in 0..4 makes that register the selected one, as shown on active_sel from the next cycle. A strobe with sel_idx of 5 or more leaves active_sel unchanged.
- R5: The interval length is taken when counting starts. A selection change or register write in the same cycle as the start, or later in the count, affects only the following interval.
- R6: A stored length of 0 acts as 1, so the pulse never appears in the cycle right after the halt is first sampled.
- R7: While timer_en=0, no pulse is produced. If timer_en is sampled 0 during a count, the count is cleared. After timer_en returns to 1, a full interval is counted.
- R8: restart_addr equals the launch_addr sampled on the most recent launch_stb cycle and is not changed by a restart.
- R9: The counter does not run while prog_halted=0. If the halt drops during a count, the count is cleared, and the next halt counts a full interval.
- R10: After a pulse, no further pulse occurs until prog_halted has returned to 0 and then risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Interval register write enable |
| cfg_idx | input | IDX_W | Interval register number for a write |
| cfg_data | input | PERIOD_W | Interval length in cycles to be written |
| sel_stb | input | 1 | Interval select strobe from the program |
| sel_idx | input | IDX_W | Interval register number to select |
| timer_en | input | 1 | Level enable for restarts |
| prog_halted | input | 1 | High while the program is halted |
| launch_stb | input | 1 | Host launch, captures launch_addr |
| launch_addr | input | ADDR_W | Program entry address |
| restart_pulse | output | 1 | One-cycle restart request |
| restart_addr | output | ADDR_W | Entry address to resume from |
| active_sel | output | IDX_W | Currently selected interval register |

## Verification
The properties assume that prog_halted, timer_en and the strobes are synchronous to clk and are driven only by the program's sequencer and the host. They also assume that a restart is modelled only as the halt input dropping, and never as an edge shared with a fresh halt. The stimulus changes every input only at the falling edge of the clock. It drops the halt input after each observed pulse, unless the test is deliberately checking that a held halt yields no second pulse. Random register numbers range up to 7, so out-of-range writes and selections occur in the random mix.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SPENT = 2'd2
  } hrt_state_e;
endpackage

// File: rtl/hrt_period_bank.sv
module hrt_period_bank #(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 16,
  parameter int IDX_W       = 3,
  parameter int RST_PERIOD  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [PERIOD_W-1:0] cfg_data,
  input  logic                sel_stb,
  input  logic [IDX_W-1:0]    sel_idx,
  output logic [IDX_W-1:0]    active_sel,
  output logic [PERIOD_W-1:0] sel_period
);
  localparam logic [IDX_W-1:0]    LAST_IDX  = IDX_W'(NUM_PERIODS - 1);
  localparam logic [PERIOD_W-1:0] RST_VALUE = PERIOD_W'(RST_PERIOD);

  logic [PERIOD_W-1:0]    per_q [NUM_PERIODS];
  logic [NUM_PERIODS-1:0] wr_hit;
  logic [IDX_W-1:0]       sel_q, sel_d;
  logic                   sel_ok;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_slot
    assign wr_hit[g] = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q[g] <= RST_VALUE;
      end else if (wr_hit[g]) begin
        per_q[g] <= cfg_data;
      end
    end
  end

  always_comb begin
    sel_ok = sel_stb && (sel_idx <= LAST_IDX);
    sel_d  = sel_ok ? sel_idx : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_ok) begin
      sel_q <= sel_d;
    end
  end

  assign active_sel = sel_q;
  assign sel_period = per_q[sel_q];
endmodule

// File: rtl/hrt_interval_counter.sv
module hrt_interval_counter
  import hrt_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                timer_en,
  input  logic                prog_halted,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                fire
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  hrt_state_e          state_q, state_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] lim_q, lim_d;
  logic                fire_q, fire_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    fire_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (timer_en && prog_halted) begin
          state_d = ST_COUNT;
          lim_d   = (period_in == '0) ? ONE : period_in;
        end
      end
      ST_COUNT: begin
        if (!timer_en || !prog_halted) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == lim_q - ONE) begin
          state_d = ST_SPENT;
          cnt_d   = '0;
          fire_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_SPENT: begin
        cnt_d = '0;
        if (!prog_halted) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lim_q   <= ONE;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      fire_q  <= fire_d;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/halt_restart_timer.sv
module halt_restart_timer #(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 16,
  parameter int ADDR_W      = 11,
  parameter int IDX_W       = $clog2(NUM_PERIODS),
  parameter int RST_PERIOD  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [PERIOD_W-1:0] cfg_data,
  input  logic                sel_stb,
  input  logic [IDX_W-1:0]    sel_idx,
  input  logic                timer_en,
  input  logic                prog_halted,
  input  logic                launch_stb,
  input  logic [ADDR_W-1:0]   launch_addr,
  output logic                restart_pulse,
  output logic [ADDR_W-1:0]   restart_addr,
  output logic [IDX_W-1:0]    active_sel
);
  logic [PERIOD_W-1:0] sel_period;
  logic [ADDR_W-1:0]   entry_q;

  hrt_period_bank #(
    .NUM_PERIODS(NUM_PERIODS),
    .PERIOD_W   (PERIOD_W),
    .IDX_W      (IDX_W),
    .RST_PERIOD (RST_PERIOD)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_data  (cfg_data),
    .sel_stb   (sel_stb),
    .sel_idx   (sel_idx),
    .active_sel(active_sel),
    .sel_period(sel_period)
  );

  hrt_interval_counter #(
    .PERIOD_W(PERIOD_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_en   (timer_en),
    .prog_halted(prog_halted),
    .period_in  (sel_period),
    .fire       (restart_pulse)
  );

  // Entry address held from the last host launch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
    end else if (launch_stb) begin
      entry_q <= launch_addr;
    end
  end

  assign restart_addr = entry_q;
endmodule

// File: rtl/hrt_checker.sv
module hrt_checker #(
  parameter int NUM_PERIODS = 5,
  parameter int ADDR_W      = 11,
  parameter int IDX_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_stb,
  input logic [IDX_W-1:0]  sel_idx,
  input logic              timer_en,
  input logic              prog_halted,
  input logic              launch_stb,
  input logic              restart_pulse,
  input logic [ADDR_W-1:0] restart_addr,
  input logic [IDX_W-1:0]  active_sel
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);

  p_sel_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stb && (int'(sel_idx) >= NUM_PERIODS)) |=> $stable(active_sel));

  p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_sel) < NUM_PERIODS);

  p_no_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_halted) |=> !restart_pulse);

  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_en |=> !restart_pulse);

  p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_stb |=> $stable(restart_addr));

  p_quiet_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_halted |=> !restart_pulse);
endmodule

bind halt_restart_timer hrt_checker #(
  .NUM_PERIODS(NUM_PERIODS),
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W)
) u_hrt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_stb      (sel_stb),
  .sel_idx      (sel_idx),
  .timer_en     (timer_en),
  .prog_halted  (prog_halted),
  .launch_stb   (launch_stb),
  .restart_pulse(restart_pulse),
  .restart_addr (restart_addr),
  .active_sel   (active_sel)
);

// File: tb/halt_restart_timer_test.sv
`timescale 1ns/1ps
module halt_restart_timer_test;
  localparam int NP = 5;
  localparam int PW = 16;
  localparam int AW = 11;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, sel_stb, timer_en, prog_halted, launch_stb;
  logic [IW-1:0] cfg_idx, sel_idx;
  logic [PW-1:0] cfg_data;
  logic [AW-1:0] launch_addr;
  logic          restart_pulse;
  logic [AW-1:0] restart_addr;
  logic [IW-1:0] active_sel;

  int tests = 0;
  int fails = 0;
  int per_m [NP];
  int sel_m;

  always #10 clk = ~clk;

  halt_restart_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .sel_stb(sel_stb), .sel_idx(sel_idx),
    .timer_en(timer_en), .prog_halted(prog_halted), .launch_stb(launch_stb),
    .launch_addr(launch_addr), .restart_pulse(restart_pulse),
    .restart_addr(restart_addr), .active_sel(active_sel)
  );

  function automatic int eff_len(int s);
    return (per_m[s] == 0) ? 1 : per_m[s];
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_period(int i, int v);
    cfg_we = 1'b1; cfg_idx = IW'(i); cfg_data = PW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (i < NP) per_m[i] = v;
  endtask

  task automatic select(int i);
    sel_stb = 1'b1; sel_idx = IW'(i);
    @(negedge clk);
    sel_stb = 1'b0;
    if (i < NP) sel_m = i;
  endtask

  // Called at a negedge after the condition that starts counting was applied.
  // Returns the cycle count from the sampling edge to the pulse, or -1.
  task automatic wait_pulse(int limit, output int got);
    got = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      cfg_we = 1'b0; sel_stb = 1'b0;
      if (restart_pulse) begin got = k - 1; break; end
    end
  endtask

  task automatic quiet_for(int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (restart_pulse) seen = 1;
    end
  endtask

  // Full interval: raise halt, measure, check one-cycle pulse, release halt.
  task automatic interval(string tag, int exp);
    int got;
    prog_halted = 1'b1;
    wait_pulse(exp + 6, got);
    chk(tag, got, exp);
    @(negedge clk);
    chk({tag, " one-cycle pulse R2"}, int'(restart_pulse), 0);
    prog_halted = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int got, seen, old_len, dummy;
    dummy = int'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 0; sel_stb = 0; timer_en = 0; prog_halted = 0;
    launch_stb = 0; cfg_idx = 0; sel_idx = 0; cfg_data = 0; launch_addr = 0;
    for (int i = 0; i < NP; i++) per_m[i] = 8;
    sel_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pulse", int'(restart_pulse), 0);
    chk("R1 active_sel", int'(active_sel), 0);
    chk("R1 restart_addr", int'(restart_addr), 0);
    timer_en = 1'b1;
    interval("R1 R2 default period", 8);

    // R8 launch address capture, held across restart
    launch_stb = 1'b1; launch_addr = AW'(11'h123);
    @(negedge clk);
    launch_stb = 1'b0;
    chk("R8 addr captured", int'(restart_addr), 11'h123);
    interval("R8 interval", 8);
    chk("R8 addr after restart", int'(restart_addr), 11'h123);

    // R3 / R4 write and select
    write_period(2, 3);
    select(2);
    chk("R4 select 2", int'(active_sel), 2);
    interval("R3 period 3", 3);
    write_period(5, 1);
    write_period(7, 1);
    interval("R3 out-of-range write ignored", 3);
    select(6);
    chk("R4 select 6 ignored", int'(active_sel), 2);

    // R6 zero period
    write_period(4, 0);
    select(4);
    interval("R6 zero acts as one", 1);

    // R5 selection and write at count start apply next interval
    write_period(1, 12);
    select(0);
    old_len = eff_len(0);
    prog_halted = 1'b1; sel_stb = 1'b1; sel_idx = 3'd1; sel_m = 1;
    wait_pulse(old_len + 6, got);
    chk("R5 old length kept", got, old_len);
    @(negedge clk); prog_halted = 1'b0; @(negedge clk);
    interval("R5 new selection", 12);
    prog_halted = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd1; cfg_data = 16'd5; per_m[1] = 5;
    wait_pulse(18, got);
    chk("R5 write during count", got, 12);
    @(negedge clk); prog_halted = 1'b0; @(negedge clk);
    interval("R5 written length", 5);

    // R7 enable drop clears count
    write_period(3, 10);
    select(3);
    prog_halted = 1'b1;
    repeat (4) @(negedge clk);
    timer_en = 1'b0;
    quiet_for(25, seen);
    chk("R7 no pulse while disabled", seen, 0);
    timer_en = 1'b1;
    wait_pulse(16, got);
    chk("R7 full interval after re-enable", got, 10);
    // R10 held halt gives no second pulse
    quiet_for(30, seen);
    chk("R10 no repeat while halted", seen, 0);
    prog_halted = 1'b0; @(negedge clk);

    // R9 running: no counting; halt drop clears
    quiet_for(30, seen);
    chk("R9 no pulse while running", seen, 0);
    prog_halted = 1'b1;
    repeat (6) @(negedge clk);
    prog_halted = 1'b0;
    repeat (2) @(negedge clk);
    interval("R9 full interval after abort", 10);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int wi, wv, si;
      wi = int'($urandom_range(0, 7));
      wv = int'($urandom_range(0, 15));
      si = int'($urandom_range(0, 7));
      write_period(wi, wv);
      select(si);
      chk("R4 random select", int'(active_sel), sel_m);
      interval("R2 random interval", eff_len(sel_m));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule